// File: doc/BRIEF.md
# Non-Blocking Atomic Request Queue

This block sits beside one core and takes the atomic reduction requests that the core offloads. The core's instruction counts as done as soon as the request is written into a slot. The core stalls only when every slot is taken. Each slot keeps the translated physical address, the operation code and the operand. The slot stays reserved until the logic layer that finished the work returns a release notice carrying the slot number.

Requests leave in the order they were accepted, at most one per cycle. At issue time the queue asks the private cache whether the target line is resident. A non-resident line skips the private cache, and the request goes out only on the network port toward the shared cache or memory. A resident line is sent to the private cache's logic layer and to the network port in the same cycle, with a flag on the network copy. Either way, only a release notice from the shared side frees the slot. That notice comes from memory when the shared cache misses. Slots are handed out lowest-free-number first, and release notices may arrive in any order.

Top module: `atomic_req_queue`

The issue controller has two states. In `ISS_IDLE` no request is presented. `ISS_IDLE -> ISS_SEND` is taken when the order FIFO holds a slot number, and that slot is loaded. `ISS_SEND` stays in `ISS_SEND` while the presented request waits. It also stays in `ISS_SEND` when the request fires and another is pending, loading the next one in the same cycle. `ISS_SEND -> ISS_IDLE` is taken when the request fires and nothing else is pending.

## Requirements
- R1: After reset, enq_ready is 1, net_valid and l1_valid are 0, and rel_err is 0.
- R2: A request is accepted on every cycle with enq_valid and enq_ready both high. After DEPTH acceptances with no release, enq_ready is 0 and further requests are not accepted and never issued.
- R3: Requests are presented on the network port in acceptance order. Address, operation code and operand are unchanged. A new request can be presented on every cycle. Slots taken from an empty queue are numbered 0, 1, 2 and so on.
- R4: When lkp_hit is 0 for the presented request, l1_valid is 0 and net_l1_copy is 0. The request fires on net_ready alone.
- R5: When lkp_hit is 1, l1_valid and net_valid are both high with the same address, operation and operand, and net_l1_copy is 1. The request fires only when net_ready and l1_ready are both 1.
- R6: While a presented request has not fired, net_valid stays 1 and its slot number and contents stay unchanged.
- R7: A release notice (rel_valid with rel_id) for a slot that has been issued and not yet released frees that slot. From a full queue, enq_ready is 1 in the cycle after the notice.
- R8: Releases may come in any order. A new request takes the lowest-numbered free slot.
- R9: A release notice for a slot that is not issued-and-outstanding frees nothing. From the next cycle, rel_err is 1 and it stays 1 until reset.
- R10: Whenever net_valid is 1, lkp_valid is 1 and lkp_addr equals net_addr.
- R11: A request accepted into an empty, idle queue is first presented two clock edges after the edge that accepted it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enq_valid | input | 1 | Core offers a request |
| enq_ready | output | 1 | A slot is free |
| enq_addr | input | ADDR_W | Physical address of the target word |
| enq_op | input | OP_W | Reduction operation code |
| enq_operand | input | DATA_W | Operand value |
| lkp_valid | output | 1 | Residency lookup is active |
| lkp_addr | output | ADDR_W | Address being looked up in the private cache |
| lkp_hit | input | 1 | Line is resident in the private cache |
| l1_valid | output | 1 | Request to the private-cache logic layer |
| l1_ready | input | 1 | Private-cache logic layer accepts |
| l1_addr | output | ADDR_W | Address toward the private cache |
| l1_op | output | OP_W | Operation toward the private cache |
| l1_operand | output | DATA_W | Operand toward the private cache |
| net_valid | output | 1 | Request toward the shared level |
| net_ready | input | 1 | Network accepts |
| net_addr | output | ADDR_W | Address toward the shared level |
| net_op | output | OP_W | Operation toward the shared level |
| net_operand | output | DATA_W | Operand toward the shared level |
| net_id | output | ID_W | Slot number returned in the release notice |
| net_l1_copy | output | 1 | A copy also went to the private cache |
| rel_valid | input | 1 | Release notice from the shared side |
| rel_id | input | ID_W | Slot being released |
| rel_err | output | 1 | Sticky flag for a release of a non-outstanding slot |

## Verification
A corrupt slot pool shows at the ports in one of two ways. Either enq_ready drops after fewer than DEPTH acceptances, or it does not drop after DEPTH. A reused slot number can appear twice on net_id before its release. Both show up within one fill of the queue. An order FIFO that skips or repeats an entry shows up on the very next issue as a wrong address or slot number. An issue controller in the wrong state shows in a single cycle: net_valid is high with nothing pending, or an accepted request is late. A faulty routing decision shows on l1_valid and net_l1_copy in the cycle the request is presented.

// File: rtl/aq_pkg.sv
package aq_pkg;
    typedef enum logic [0:0] {
        ISS_IDLE = 1'b0,
        ISS_SEND = 1'b1
    } iss_state_e;

    function automatic int next_wrap(input int p, input int depth);
        return (p == depth - 1) ? 0 : p + 1;
    endfunction
endpackage

// File: rtl/aq_slot_pool.sv
module aq_slot_pool #(
    parameter int DEPTH = 64,
    parameter int ID_W  = $clog2(DEPTH),
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            take,
    output logic [ID_W-1:0] alloc_id,
    output logic            full,
    input  logic            mark,
    input  logic [ID_W-1:0] mark_id,
    input  logic            rel_valid,
    input  logic [ID_W-1:0] rel_id,
    output logic            rel_err
);
    logic [DEPTH-1:0] used;
    logic [DEPTH-1:0] flying;
    logic [CNT_W-1:0] count;
    logic             rel_ok;

    // lowest-numbered free slot wins
    always_comb begin
        alloc_id = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (!used[i]) alloc_id = ID_W'(i);
        end
    end

    assign rel_ok = rel_valid && used[rel_id] && flying[rel_id];
    assign full   = (count == CNT_W'(DEPTH));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            used    <= '0;
            flying  <= '0;
            count   <= '0;
            rel_err <= 1'b0;
        end else begin
            if (take) used[alloc_id] <= 1'b1;
            if (mark) flying[mark_id] <= 1'b1;
            if (rel_ok) begin
                used[rel_id]   <= 1'b0;
                flying[rel_id] <= 1'b0;
            end
            if (rel_valid && !rel_ok) rel_err <= 1'b1;
            case ({take, rel_ok})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end
endmodule

// File: rtl/aq_id_fifo.sv
module aq_id_fifo #(
    parameter int DEPTH = 64,
    parameter int ID_W  = $clog2(DEPTH),
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            push,
    input  logic [ID_W-1:0] push_id,
    input  logic            pop,
    output logic [ID_W-1:0] head_id,
    output logic            empty
);
    import aq_pkg::*;

    logic [ID_W-1:0]  slots [DEPTH];
    logic [ID_W-1:0]  wr_ptr;
    logic [ID_W-1:0]  rd_ptr;
    logic [CNT_W-1:0] level;

    assign empty   = (level == '0);
    assign head_id = slots[rd_ptr];

    always_ff @(posedge clk) begin
        if (push) slots[wr_ptr] <= push_id;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
        end else begin
            if (push) wr_ptr <= ID_W'(next_wrap(int'(wr_ptr), DEPTH));
            if (pop)  rd_ptr <= ID_W'(next_wrap(int'(rd_ptr), DEPTH));
            case ({push, pop})
                2'b10:   level <= level + 1'b1;
                2'b01:   level <= level - 1'b1;
                default: level <= level;
            endcase
        end
    end
endmodule

// File: rtl/aq_issue_fsm.sv
module aq_issue_fsm #(
    parameter int ADDR_W = 40,
    parameter int OP_W   = 4,
    parameter int DATA_W = 64,
    parameter int ID_W   = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pend_empty,
    input  logic [ID_W-1:0]   head_id,
    input  logic [ADDR_W-1:0] head_addr,
    input  logic [OP_W-1:0]   head_op,
    input  logic [DATA_W-1:0] head_operand,
    input  logic              lkp_hit,
    input  logic              net_ready,
    input  logic              l1_ready,
    output logic              pop,
    output logic              fire,
    output logic              presenting,
    output logic              send_l1,
    output logic [ID_W-1:0]   cur_id,
    output logic [ADDR_W-1:0] cur_addr,
    output logic [OP_W-1:0]   cur_op,
    output logic [DATA_W-1:0] cur_operand
);
    import aq_pkg::*;

    iss_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ISS_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        presenting = 1'b0;
        send_l1    = 1'b0;
        fire       = 1'b0;
        pop        = 1'b0;
        state_d    = state_q;
        unique case (state_q)
            ISS_IDLE: begin
                if (!pend_empty) begin
                    pop     = 1'b1;
                    state_d = ISS_SEND;
                end
            end
            ISS_SEND: begin
                presenting = 1'b1;
                send_l1    = lkp_hit;
                fire       = net_ready && (l1_ready || !lkp_hit);
                if (fire) begin
                    if (pend_empty) state_d = ISS_IDLE;
                    else            pop     = 1'b1;
                end
            end
            default: state_d = ISS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_id      <= '0;
            cur_addr    <= '0;
            cur_op      <= '0;
            cur_operand <= '0;
        end else if (pop) begin
            cur_id      <= head_id;
            cur_addr    <= head_addr;
            cur_op      <= head_op;
            cur_operand <= head_operand;
        end
    end
endmodule

// File: rtl/atomic_req_queue.sv
module atomic_req_queue #(
    parameter int DEPTH  = 64,
    parameter int ADDR_W = 40,
    parameter int OP_W   = 4,
    parameter int DATA_W = 64,
    parameter int ID_W   = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enq_valid,
    output logic              enq_ready,
    input  logic [ADDR_W-1:0] enq_addr,
    input  logic [OP_W-1:0]   enq_op,
    input  logic [DATA_W-1:0] enq_operand,
    output logic              lkp_valid,
    output logic [ADDR_W-1:0] lkp_addr,
    input  logic              lkp_hit,
    output logic              l1_valid,
    input  logic              l1_ready,
    output logic [ADDR_W-1:0] l1_addr,
    output logic [OP_W-1:0]   l1_op,
    output logic [DATA_W-1:0] l1_operand,
    output logic              net_valid,
    input  logic              net_ready,
    output logic [ADDR_W-1:0] net_addr,
    output logic [OP_W-1:0]   net_op,
    output logic [DATA_W-1:0] net_operand,
    output logic [ID_W-1:0]   net_id,
    output logic              net_l1_copy,
    input  logic              rel_valid,
    input  logic [ID_W-1:0]   rel_id,
    output logic              rel_err
);
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic              take;
    logic              full;
    logic [ID_W-1:0]   alloc_id;
    logic              pend_empty;
    logic [ID_W-1:0]   head_id;
    logic              pop;
    logic              fire;
    logic              presenting;
    logic              send_l1;
    logic [ID_W-1:0]   cur_id;
    logic [ADDR_W-1:0] cur_addr;
    logic [OP_W-1:0]   cur_op;
    logic [DATA_W-1:0] cur_operand;

    logic [ADDR_W-1:0] slot_addr    [DEPTH];
    logic [OP_W-1:0]   slot_op      [DEPTH];
    logic [DATA_W-1:0] slot_operand [DEPTH];

    assign enq_ready = !full;
    assign take      = enq_valid && !full;

    always_ff @(posedge clk) begin
        if (take) begin
            slot_addr[alloc_id]    <= enq_addr;
            slot_op[alloc_id]      <= enq_op;
            slot_operand[alloc_id] <= enq_operand;
        end
    end

    aq_slot_pool #(.DEPTH(DEPTH), .ID_W(ID_W), .CNT_W(CNT_W)) u_pool (
        .clk       (clk),
        .rst_n     (rst_n),
        .take      (take),
        .alloc_id  (alloc_id),
        .full      (full),
        .mark      (fire),
        .mark_id   (cur_id),
        .rel_valid (rel_valid),
        .rel_id    (rel_id),
        .rel_err   (rel_err)
    );

    aq_id_fifo #(.DEPTH(DEPTH), .ID_W(ID_W), .CNT_W(CNT_W)) u_order (
        .clk     (clk),
        .rst_n   (rst_n),
        .push    (take),
        .push_id (alloc_id),
        .pop     (pop),
        .head_id (head_id),
        .empty   (pend_empty)
    );

    aq_issue_fsm #(.ADDR_W(ADDR_W), .OP_W(OP_W), .DATA_W(DATA_W), .ID_W(ID_W)) u_issue (
        .clk          (clk),
        .rst_n        (rst_n),
        .pend_empty   (pend_empty),
        .head_id      (head_id),
        .head_addr    (slot_addr[head_id]),
        .head_op      (slot_op[head_id]),
        .head_operand (slot_operand[head_id]),
        .lkp_hit      (lkp_hit),
        .net_ready    (net_ready),
        .l1_ready     (l1_ready),
        .pop          (pop),
        .fire         (fire),
        .presenting   (presenting),
        .send_l1      (send_l1),
        .cur_id       (cur_id),
        .cur_addr     (cur_addr),
        .cur_op       (cur_op),
        .cur_operand  (cur_operand)
    );

    assign lkp_valid   = presenting;
    assign lkp_addr    = cur_addr;
    assign net_valid   = presenting;
    assign net_addr    = cur_addr;
    assign net_op      = cur_op;
    assign net_operand = cur_operand;
    assign net_id      = cur_id;
    assign net_l1_copy = send_l1;
    assign l1_valid    = send_l1;
    assign l1_addr     = cur_addr;
    assign l1_op       = cur_op;
    assign l1_operand  = cur_operand;
endmodule

// File: rtl/aq_checker.sv
module aq_checker #(
    parameter int ADDR_W = 40,
    parameter int OP_W   = 4,
    parameter int DATA_W = 64,
    parameter int ID_W   = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              enq_ready,
    input logic              lkp_valid,
    input logic [ADDR_W-1:0] lkp_addr,
    input logic              l1_valid,
    input logic [ADDR_W-1:0] l1_addr,
    input logic [OP_W-1:0]   l1_op,
    input logic [DATA_W-1:0] l1_operand,
    input logic              net_valid,
    input logic              net_ready,
    input logic [ADDR_W-1:0] net_addr,
    input logic [OP_W-1:0]   net_op,
    input logic [DATA_W-1:0] net_operand,
    input logic [ID_W-1:0]   net_id,
    input logic              net_l1_copy,
    input logic              rel_valid,
    input logic              rel_err
);
    // R4: a request without the copy flag never reaches the private cache
    a_r4_miss_bypasses: assert property (@(posedge clk) disable iff (!rst_n)
        (net_valid && !net_l1_copy) |-> !l1_valid);

    // R5: the private-cache copy always travels with a flagged network request
    a_r5_dual_issue: assert property (@(posedge clk) disable iff (!rst_n)
        l1_valid |-> (net_valid && net_l1_copy && l1_addr == net_addr
                      && l1_op == net_op && l1_operand == net_operand));

    // R6: a stalled request keeps its slot and contents
    a_r6_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
        (net_valid && !net_ready) |=> (net_valid && $stable(net_id)
                                       && $stable(net_addr) && $stable(net_operand)));

    // R7: a full queue reopens only after a release notice
    a_r7_reopen_on_release: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(enq_ready) |-> $past(rel_valid));

    // R9: the release error flag is sticky
    a_r9_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        rel_err |=> rel_err);

    // R10: the residency lookup follows the presented request
    a_r10_lookup_tracks: assert property (@(posedge clk) disable iff (!rst_n)
        net_valid |-> (lkp_valid && lkp_addr == net_addr));
endmodule

bind atomic_req_queue aq_checker #(
    .ADDR_W(ADDR_W), .OP_W(OP_W), .DATA_W(DATA_W), .ID_W(ID_W)
) u_aq_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .enq_ready   (enq_ready),
    .lkp_valid   (lkp_valid),
    .lkp_addr    (lkp_addr),
    .l1_valid    (l1_valid),
    .l1_addr     (l1_addr),
    .l1_op       (l1_op),
    .l1_operand  (l1_operand),
    .net_valid   (net_valid),
    .net_ready   (net_ready),
    .net_addr    (net_addr),
    .net_op      (net_op),
    .net_operand (net_operand),
    .net_id      (net_id),
    .net_l1_copy (net_l1_copy),
    .rel_valid   (rel_valid),
    .rel_err     (rel_err)
);

// File: tb/atomic_req_queue_test.sv
module atomic_req_queue_test;
    localparam int DEPTH  = 8;
    localparam int ADDR_W = 16;
    localparam int OP_W   = 3;
    localparam int DATA_W = 16;
    localparam int ID_W   = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic enq_valid = 1'b0;
    logic enq_ready;
    logic [ADDR_W-1:0] enq_addr = '0;
    logic [OP_W-1:0] enq_op = '0;
    logic [DATA_W-1:0] enq_operand = '0;
    logic lkp_valid;
    logic [ADDR_W-1:0] lkp_addr;
    logic lkp_hit;
    logic l1_valid;
    logic l1_ready = 1'b0;
    logic [ADDR_W-1:0] l1_addr;
    logic [OP_W-1:0] l1_op;
    logic [DATA_W-1:0] l1_operand;
    logic net_valid;
    logic net_ready = 1'b0;
    logic [ADDR_W-1:0] net_addr;
    logic [OP_W-1:0] net_op;
    logic [DATA_W-1:0] net_operand;
    logic [ID_W-1:0] net_id;
    logic net_l1_copy;
    logic rel_valid = 1'b0;
    logic [ID_W-1:0] rel_id = '0;
    logic rel_err;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // residency model: a line is resident when address bit 6 is set
    assign lkp_hit = lkp_addr[6];

    always #10 clk = ~clk;

    atomic_req_queue #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .OP_W(OP_W),
                       .DATA_W(DATA_W)) uut (.*);

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [ADDR_W-1:0] fill_addr(input int i);
        return ADDR_W'(i * 64 + i);
    endfunction

    task automatic release_slot(input int id);
        @(negedge clk);
        rel_valid = 1'b1;
        rel_id = ID_W'(id);
        @(negedge clk);
        rel_valid = 1'b0;
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=1 expected=0");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 enq_ready", enq_ready, 1);
        chk("R1 net_valid", net_valid, 0);
        chk("R1 l1_valid", l1_valid, 0);
        chk("R1 rel_err", rel_err, 0);

        // fill the queue with the network stalled
        for (int i = 0; i < DEPTH; i++) begin
            chk("R2 ready while filling", enq_ready, 1);
            enq_valid = 1'b1;
            enq_addr = fill_addr(i);
            enq_op = OP_W'(i);
            enq_operand = DATA_W'(16'h100 + i);
            @(negedge clk);
            if (i == 0) chk("R11 not yet presented", net_valid, 0);
        end
        chk("R2 full drops ready", enq_ready, 0);
        enq_addr = 16'h7777;
        enq_operand = 16'hDEAD;
        @(negedge clk);
        enq_valid = 1'b0;
        for (int k = 0; k < 2; k++) begin
            chk("R6 held valid", net_valid, 1);
            chk("R6 held id", net_id, 0);
            chk("R6 held addr", net_addr, fill_addr(0));
            @(negedge clk);
        end

        // drain in order, one per cycle
        for (int i = 0; i < DEPTH; i++) begin
            chk("R3 valid", net_valid, 1);
            chk("R3 order addr", net_addr, fill_addr(i));
            chk("R3 op", net_op, i);
            chk("R3 operand", net_operand, 16'h100 + i);
            chk("R3 slot number", net_id, i);
            chk("R10 lookup addr", lkp_addr, fill_addr(i));
            chk("R4/R5 copy flag", net_l1_copy, i & 1);
            chk("R4/R5 l1_valid", l1_valid, i & 1);
            if ((i & 1) != 0) chk("R5 l1 operand", l1_operand, 16'h100 + i);
            if (i == 0) begin
                net_ready = 1'b1;
                l1_ready = 1'b1;
            end
            @(negedge clk);
        end
        chk("R2 rejected request never issued", net_valid, 0);
        chk("R2 still full", enq_ready, 0);

        // out-of-order releases and reuse of the lowest free slot
        release_slot(5);
        chk("R7 reopened", enq_ready, 1);
        chk("R7 no error", rel_err, 0);
        release_slot(2);
        enq_valid = 1'b1;
        enq_addr = 16'h0040;
        enq_op = 3'd5;
        enq_operand = 16'hABCD;
        @(negedge clk);
        enq_valid = 1'b0;
        chk("R11 one edge later idle", net_valid, 0);
        @(negedge clk);
        chk("R11 presented two edges later", net_valid, 1);
        chk("R8 lowest free slot", net_id, 2);
        chk("R8 operand", net_operand, 16'hABCD);
        @(negedge clk);
        chk("R3 drained", net_valid, 0);

        // valid release, then a release of an already-free slot
        net_ready = 1'b0;
        release_slot(7);
        chk("R9 no error on good release", rel_err, 0);
        release_slot(5);
        chk("R9 error raised", rel_err, 1);
        for (int i = 0; i < 3; i++) begin
            chk("R9 bad release freed nothing", enq_ready, (i < 2) ? 1 : 0);
            enq_valid = 1'b1;
            enq_addr = (i == 0) ? 16'h0040 : 16'h0082;
            enq_op = OP_W'(i + 1);
            enq_operand = DATA_W'(16'h200 + i);
            @(negedge clk);
        end
        enq_valid = 1'b0;
        chk("R9 error sticky", rel_err, 1);

        // hit waits for both readies, miss ignores l1_ready
        chk("R5 hit presented", net_id, 5);
        chk("R5 hit l1_valid", l1_valid, 1);
        net_ready = 1'b1;
        l1_ready = 1'b0;
        @(negedge clk);
        chk("R5 hit stalls on l1_ready", net_id, 5);
        chk("R5 still valid", net_valid, 1);
        l1_ready = 1'b1;
        @(negedge clk);
        chk("R8 second slot", net_id, 7);
        chk("R4 miss no l1", l1_valid, 0);
        chk("R4 miss flag", net_l1_copy, 0);
        l1_ready = 1'b0;
        @(negedge clk);
        chk("R4 miss fired without l1_ready", net_valid, 0);
        repeat (3) @(negedge clk);
        chk("R2 refused request stays out", net_valid, 0);
        chk("R9 error still sticky", rel_err, 1);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule